// File: doc/BRIEF.md
# Triggered ADC Capture Sequencer

This block fills a 32-bit-wide capture buffer with samples from a pair of 12-bit converters. A small host register interface sets a control word and writes a top-address word; writing the top address arms a capture. After a software start (immediately) or an external start edge, the block issues a conversion strobe at a selectable fraction of its clock, drops the converter's pipeline results and any decimated results, and writes packed words into the buffer from the top address down to address zero.

Each word holds either both channels of one sample instant, or two consecutive samples of channel 1. When address zero is written, an active-low ready bit in the status word reports completion and, if enabled, an interrupt is raised. The interrupt is held until the host reads the buffer. Samples reach the buffer over a write strobe with no back-pressure. The converter cannot be stalled, so the memory must accept a write in any cycle where `mem_wr_en` is high. A host buffer read is shown to the block only as a one-cycle strobe.

Top module: `adc_capture_seq`

## Requirements
- R1: A capture writes exactly top+1 words, at addresses top, top-1, ... 0 in that order, where top is `host_wr_data[19:0]` of the arm write (`host_wr_addr`=1).
- R2: With software start, the first conversion strobe occurs in the cycle after the arm write. The first four strobe results are discarded as converter latency, so the first stored sample is the one converted at that first strobe.
- R3: With the external-start bit (control bit 7) set, an arm write waits with no strobes and no writes until a rising edge of `ext_start`. The first strobe follows in the next cycle. Further rising edges during the capture or after it ends have no effect.
- R4: The rate field (control bits 1:0, value n) spaces conversion strobes 2^n cycles apart.
- R5: The decimation field (control bits 5:2, code c) keeps every 2^(c-1)-th converted result. Code 0 keeps every result, and codes 9 to 15 behave as code 8 (every 128th).
- R6: In dual mode (control bit 6 = 0), channel 1 occupies word bits 11:0, channel 2 occupies bits 27:16, and all other bits are zero.
- R7: In single mode (control bit 6 = 1), the earlier of two consecutive kept channel-1 samples goes to bits 11:0 and the later one to bits 27:16. `adc_ch2` is ignored.
- R8: `host_status[0]` is 1 from reset and while a capture is armed or running. It drops to 0 in the cycle the address-0 write appears, after which strobes and writes stop.
- R9: With interrupt enable (control bit 8) set, `irq` rises together with completion. With the bit clear, `irq` stays 0.
- R10: A `host_buf_rd` strobe while `irq` is high clears `irq` in the next cycle. `irq` is also cleared by an arm write.
- R11: An arm write during a capture, or after one has completed, restarts from the new top address and shows `host_status[0]`=1 in the next cycle.
- R12: After reset, `irq`, `mem_wr_en` and `adc_conv_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr_en | input | 1 | Host register write strobe |
| host_wr_addr | input | 1 | 0 selects the control word, 1 the top-address (arm) word |
| host_wr_data | input | 32 | Host write data |
| host_status | output | 32 | Status word; bit 0 is the active-low ready flag |
| host_buf_rd | input | 1 | One-cycle strobe marking a host read of the buffer |
| ext_start | input | 1 | External start input, rising edge active |
| adc_conv_en | output | 1 | Conversion strobe to the converters |
| adc_ch1 | input | 12 | Channel 1 converter result bus |
| adc_ch2 | input | 12 | Channel 2 converter result bus |
| mem_wr_en | output | 1 | Buffer write strobe |
| mem_wr_addr | output | 20 | Buffer write address |
| mem_wr_data | output | 32 | Packed buffer word |
| irq | output | 1 | Completion interrupt request |

## Verification
A wrong decimation or latency count moves every stored code, and a wrong rate divider stretches the time to completion. The bench therefore compares full buffer contents against codes computed from the strobe count, and compares the completion cycle against the exact cycle count. A down-counter or packer half-flag that slips shows up at the very next write, as an out-of-order address or a swapped field. A trigger or state fault shows up as writes during the wait, or as a restarted address sequence within one strobe period of the stray edge. Interrupt faults appear one cycle after completion or after the read strobe.

// File: rtl/adc_cap_pkg.sv
package adc_cap_pkg;
  localparam int RATE_W   = 2;
  localparam int DEC_W    = 4;
  localparam int DLOG_W   = 3;
  localparam int DEC_MAXC = 8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RUN  = 2'd2,
    ST_DONE = 2'd3
  } cap_state_e;

  // control word layout, LSB first: rate, decimation, single, ext enable, irq enable
  typedef struct packed {
    logic              irq_en;
    logic              ext_en;
    logic              single;
    logic [DEC_W-1:0]  dec_code;
    logic [RATE_W-1:0] rate_sel;
  } cap_ctrl_t;

  function automatic logic [DLOG_W-1:0] dec_log(input logic [DEC_W-1:0] code);
    if (code == '0)
      return '0;
    else if (int'(code) > DEC_MAXC)
      return DLOG_W'(DEC_MAXC - 1);
    else
      return DLOG_W'(code - 1'b1);
  endfunction
endpackage

// File: rtl/cap_rate_gen.sv
module cap_rate_gen #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             run,
  input  logic [SEL_W-1:0] rate_sel,
  output logic             tick
);
  localparam int CNT_W = (1 << SEL_W) - 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;

  always_comb begin
    lim = '0;
    for (int i = 0; i < CNT_W; i++)
      lim[i] = (i < int'(rate_sel));
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear)
      cnt <= '0;
    else if (run)
      cnt <= (cnt == lim) ? '0 : cnt + 1'b1;
  end

  assign tick = run && (cnt == '0);
endmodule

// File: rtl/cap_decim.sv
module cap_decim #(
  parameter int CODE_W = 12,
  parameter int LAT    = 4,
  parameter int DLOG_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              tick,
  input  logic [DLOG_W-1:0] dlog,
  input  logic [CODE_W-1:0] ch1_in,
  input  logic [CODE_W-1:0] ch2_in,
  output logic              smp_valid,
  output logic [CODE_W-1:0] smp1,
  output logic [CODE_W-1:0] smp2
);
  localparam int PH_W  = (1 << DLOG_W) - 1;
  localparam int LAT_W = $clog2(LAT + 1);

  logic [LAT_W-1:0] lat_cnt;
  logic [PH_W-1:0]  phase;
  logic [PH_W-1:0]  ph_lim;
  logic             lat_done;

  always_comb begin
    ph_lim = '0;
    for (int i = 0; i < PH_W; i++)
      ph_lim[i] = (i < int'(dlog));
  end

  assign lat_done = (lat_cnt == LAT_W'(LAT));

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      lat_cnt <= '0;
      phase   <= '0;
    end else if (tick) begin
      if (!lat_done)
        lat_cnt <= lat_cnt + 1'b1;
      else
        phase <= (phase == ph_lim) ? '0 : phase + 1'b1;
    end
  end

  assign smp_valid = tick && lat_done && (phase == '0);
  assign smp1      = ch1_in;
  assign smp2      = ch2_in;
endmodule

// File: rtl/cap_packer.sv
module cap_packer #(
  parameter int ADDR_W = 20,
  parameter int CODE_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic [ADDR_W-1:0] top,
  input  logic              single,
  input  logic              smp_valid,
  input  logic [CODE_W-1:0] smp1,
  input  logic [CODE_W-1:0] smp2,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              last
);
  localparam int HI_LSB = DATA_W / 2;

  logic [ADDR_W-1:0] addr;
  logic              half_full;
  logic [CODE_W-1:0] hold;
  logic              emit;
  logic [CODE_W-1:0] lo_code;
  logic [CODE_W-1:0] hi_code;
  logic [DATA_W-1:0] word;

  assign emit = smp_valid && (!single || half_full);
  assign last = emit && (addr == '0);

  always_comb begin
    lo_code = single ? hold : smp1;
    hi_code = single ? smp1 : smp2;
    word    = '0;
    word[CODE_W-1:0]        = lo_code;
    word[HI_LSB +: CODE_W]  = hi_code;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr      <= '0;
      half_full <= 1'b0;
      hold      <= '0;
      wr_en     <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
    end else if (clear) begin
      addr      <= top;
      half_full <= 1'b0;
      wr_en     <= 1'b0;
    end else begin
      wr_en <= emit;
      if (emit) begin
        wr_addr <= addr;
        wr_data <= word;
        addr    <= addr - 1'b1;
      end
      if (smp_valid && single) begin
        half_full <= !half_full;
        if (!half_full)
          hold <= smp1;
      end
    end
  end
endmodule

// File: rtl/adc_capture_seq.sv
module adc_capture_seq
  import adc_cap_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int CODE_W = 12,
  parameter int DATA_W = 32,
  parameter int HOST_W = 32,
  parameter int LAT    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr_en,
  input  logic              host_wr_addr,
  input  logic [HOST_W-1:0] host_wr_data,
  output logic [HOST_W-1:0] host_status,
  input  logic              host_buf_rd,
  input  logic              ext_start,
  output logic              adc_conv_en,
  input  logic [CODE_W-1:0] adc_ch1,
  input  logic [CODE_W-1:0] adc_ch2,
  output logic              mem_wr_en,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [DATA_W-1:0] mem_wr_data,
  output logic              irq
);
  localparam int CTRL_W = $bits(cap_ctrl_t);

  cap_state_e        state;
  cap_ctrl_t         ctrl_q;
  logic [ADDR_W-1:0] top_q;
  logic [ADDR_W-1:0] top_src;
  logic              ext_q;
  logic              arm_wr;
  logic              ctrl_wr;
  logic              ext_rise;
  logic              trig_start;
  logic              clear;
  logic              run;
  logic              tick;
  logic              smp_valid;
  logic [CODE_W-1:0] smp1;
  logic [CODE_W-1:0] smp2;
  logic              last;
  logic [RATE_W-1:0] rate_sel;

  assign arm_wr     = host_wr_en && host_wr_addr;
  assign ctrl_wr    = host_wr_en && !host_wr_addr;
  assign ext_rise   = ext_start && !ext_q;
  assign trig_start = (state == ST_WAIT) && ext_rise && !arm_wr;
  assign clear      = arm_wr || trig_start;
  assign run        = (state == ST_RUN);
  assign top_src    = arm_wr ? host_wr_data[ADDR_W-1:0] : top_q;
  assign rate_sel   = ctrl_q.rate_sel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      ctrl_q <= '0;
      top_q  <= '0;
      ext_q  <= 1'b0;
      irq    <= 1'b0;
    end else begin
      ext_q <= ext_start;
      if (ctrl_wr)
        ctrl_q <= cap_ctrl_t'(host_wr_data[CTRL_W-1:0]);
      if (arm_wr) begin
        top_q <= host_wr_data[ADDR_W-1:0];
        state <= ctrl_q.ext_en ? ST_WAIT : ST_RUN;
        irq   <= 1'b0;
      end else begin
        unique case (state)
          ST_WAIT: if (ext_rise) state <= ST_RUN;
          ST_RUN:  if (last) state <= ST_DONE;
          default: ;
        endcase
        if (last && ctrl_q.irq_en)
          irq <= 1'b1;
        else if (host_buf_rd)
          irq <= 1'b0;
      end
    end
  end

  assign host_status = HOST_W'(state != ST_DONE);

  cap_rate_gen #(
    .SEL_W(RATE_W)
  ) u_rate (
    .clk(clk),
    .rst_n(rst_n),
    .clear(clear),
    .run(run),
    .rate_sel(ctrl_q.rate_sel),
    .tick(tick)
  );

  cap_decim #(
    .CODE_W(CODE_W),
    .LAT(LAT),
    .DLOG_W(DLOG_W)
  ) u_decim (
    .clk(clk),
    .rst_n(rst_n),
    .clear(clear),
    .tick(tick),
    .dlog(dec_log(ctrl_q.dec_code)),
    .ch1_in(adc_ch1),
    .ch2_in(adc_ch2),
    .smp_valid(smp_valid),
    .smp1(smp1),
    .smp2(smp2)
  );

  cap_packer #(
    .ADDR_W(ADDR_W),
    .CODE_W(CODE_W),
    .DATA_W(DATA_W)
  ) u_pack (
    .clk(clk),
    .rst_n(rst_n),
    .clear(clear),
    .top(top_src),
    .single(ctrl_q.single),
    .smp_valid(smp_valid && !clear),
    .smp1(smp1),
    .smp2(smp2),
    .wr_en(mem_wr_en),
    .wr_addr(mem_wr_addr),
    .wr_data(mem_wr_data),
    .last(last)
  );

  assign adc_conv_en = tick;
endmodule

// File: rtl/adc_capture_seq_chk.sv
module adc_capture_seq_chk
  import adc_cap_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_wr_en,
  input logic              host_wr_addr,
  input logic              host_status0,
  input logic              host_buf_rd,
  input logic              adc_conv_en,
  input logic              mem_wr_en,
  input logic [ADDR_W-1:0] mem_wr_addr,
  input logic              irq,
  input logic [1:0]        state,
  input logic [RATE_W-1:0] rate_sel
);
  logic              have_prev;
  logic [ADDR_W-1:0] prev_addr;
  logic              arm;

  assign arm = host_wr_en && host_wr_addr;

  always_ff @(posedge clk) begin
    if (!rst_n || arm) begin
      have_prev <= 1'b0;
      prev_addr <= '0;
    end else if (mem_wr_en) begin
      have_prev <= 1'b1;
      prev_addr <= mem_wr_addr;
    end
  end

  AST_ADDR_DESCEND: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en && have_prev |-> mem_wr_addr == prev_addr - 1'b1); // R1

  AST_WAIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_WAIT |-> !adc_conv_en && !mem_wr_en); // R3

  AST_RATE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    adc_conv_en && rate_sel != '0 && !arm |=> !adc_conv_en); // R4

  AST_DONE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(host_status0) |-> mem_wr_en && mem_wr_addr == '0); // R8

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_DONE |-> !adc_conv_en); // R8

  AST_IRQ_ONLY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !host_status0); // R9

  AST_IRQ_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    irq && host_buf_rd |=> !irq); // R10

  AST_REARM_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> host_status0); // R11
endmodule

bind adc_capture_seq adc_capture_seq_chk #(
  .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .host_wr_en(host_wr_en),
  .host_wr_addr(host_wr_addr),
  .host_status0(host_status[0]),
  .host_buf_rd(host_buf_rd),
  .adc_conv_en(adc_conv_en),
  .mem_wr_en(mem_wr_en),
  .mem_wr_addr(mem_wr_addr),
  .irq(irq),
  .state(state),
  .rate_sel(rate_sel)
);

// File: tb/tb_adc_capture_seq.sv
module tb_adc_capture_seq;
  localparam int AW  = 20;
  localparam int CW  = 12;
  localparam int DW  = 32;
  localparam int LAT = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          host_wr_en = 1'b0;
  logic          host_wr_addr = 1'b0;
  logic [31:0]   host_wr_data = '0;
  logic [31:0]   host_status;
  logic          host_buf_rd = 1'b0;
  logic          ext_start = 1'b0;
  logic          adc_conv_en;
  logic [CW-1:0] adc_ch1 = '0;
  logic [CW-1:0] adc_ch2 = '0;
  logic          mem_wr_en;
  logic [AW-1:0] mem_wr_addr;
  logic [DW-1:0] mem_wr_data;
  logic          irq;

  adc_capture_seq dut (
    .clk(clk), .rst_n(rst_n),
    .host_wr_en(host_wr_en), .host_wr_addr(host_wr_addr),
    .host_wr_data(host_wr_data), .host_status(host_status),
    .host_buf_rd(host_buf_rd), .ext_start(ext_start),
    .adc_conv_en(adc_conv_en), .adc_ch1(adc_ch1), .adc_ch2(adc_ch2),
    .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data), .irq(irq)
  );

  int tests = 0;
  int fails = 0;
  int adc_cnt = 0;
  int wr_cnt = 0;
  int order_err = 0;
  int exp_addr = 0;
  int base = 0;
  logic [DW-1:0] mem [64];

  initial forever #5 clk = ~clk;

  function automatic logic [CW-1:0] code1(input int n);
    return n[CW-1:0];
  endfunction
  function automatic logic [CW-1:0] code2(input int n);
    return n[CW-1:0] ^ 12'h5A5;
  endfunction

  // converter model: bus seen at strobe k carries the sample of strobe k-LAT
  initial forever begin
    @(negedge clk);
    if (adc_conv_en) begin
      adc_ch1 = code1(adc_cnt - LAT);
      adc_ch2 = code2(adc_cnt - LAT);
      adc_cnt++;
    end
  end

  // buffer model
  initial forever begin
    @(negedge clk);
    if (mem_wr_en) begin
      if (int'(mem_wr_addr) != exp_addr) order_err++;
      if (mem_wr_addr < 64) mem[mem_wr_addr[5:0]] = mem_wr_data;
      wr_cnt++;
      exp_addr--;
    end
  end

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    summary();
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] ctrl_word(input int rate, input int dec,
                                            input bit single, input bit ext,
                                            input bit irqe);
    logic [31:0] w;
    w = '0;
    w[1:0] = rate[1:0];
    w[5:2] = dec[3:0];
    w[6] = single;
    w[7] = ext;
    w[8] = irqe;
    return w;
  endfunction

  function automatic int dec_ratio(input int code);
    if (code == 0) return 1;
    if (code > 8) return 128;
    return 1 << (code - 1);
  endfunction

  function automatic logic [31:0] exp_word(input int b, input int top, input int a,
                                           input bit single, input int d);
    int w;
    int s;
    logic [31:0] r;
    w = top - a;
    r = '0;
    if (single) begin
      s = b + 2 * w * d;
      r[11:0]  = code1(s);
      r[27:16] = code1(s + d);
    end else begin
      s = b + w * d;
      r[11:0]  = code1(s);
      r[27:16] = code2(s);
    end
    return r;
  endfunction

  task automatic hw(input bit sel, input logic [31:0] d);
    @(negedge clk);
    host_wr_en = 1'b1;
    host_wr_addr = sel;
    host_wr_data = d;
    @(posedge clk);
    #1;
    host_wr_en = 1'b0;
  endtask

  task automatic mark_start(input int top);
    base = adc_cnt;
    wr_cnt = 0;
    order_err = 0;
    exp_addr = top;
  endtask

  task automatic wait_done(output int cyc);
    int n;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (host_status[0] && n < 40000);
    cyc = n - 1;
  endtask

  task automatic check_buf(input int top, input bit single, input int d,
                           input string req);
    bit ok;
    logic [31:0] a_got;
    logic [31:0] a_exp;
    ok = 1'b1;
    a_got = '0;
    a_exp = '0;
    for (int a = 0; a <= top; a++) begin
      if (ok && mem[a] !== exp_word(base, top, a, single, d)) begin
        ok = 1'b0;
        a_got = mem[a];
        a_exp = exp_word(base, top, a, single, d);
      end
    end
    chk(ok, req, "buffer content", a_got, a_exp);
  endtask

  task automatic run_cap(input int rate, input int dec, input bit single, input int top);
    int cyc;
    int d;
    int s;
    int expc;
    hw(1'b0, ctrl_word(rate, dec, single, 1'b0, 1'b0));
    hw(1'b1, top);
    mark_start(top);
    wait_done(cyc);
    d = dec_ratio(dec);
    s = (top + 1) * (single ? 2 : 1);
    expc = 1 + (LAT + (s - 1) * d) * (1 << rate);
    chk(cyc == expc, "R4 R5", "cycles to completion", cyc, expc);
    chk(wr_cnt == top + 1 && order_err == 0, "R1", "write count/order",
        wr_cnt + 1000 * order_err, top + 1);
    check_buf(top, single, d, single ? "R7" : "R6");
    chk(irq == 1'b0, "R9", "irq with enable clear", irq, 0);
  endtask

  initial begin
    int cyc;
    int snap;
    int wsnap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state, R8 ready flag starts at 1
    chk(host_status[0] == 1'b1, "R8", "status after reset", host_status, 1);
    chk(irq == 1'b0 && mem_wr_en == 1'b0 && adc_conv_en == 1'b0, "R12",
        "outputs after reset", {irq, mem_wr_en, adc_conv_en}, 0);

    // R2: first stored sample is from the first strobe after the arm write
    hw(1'b0, ctrl_word(0, 0, 1'b0, 1'b0, 1'b0));
    hw(1'b1, 2);
    mark_start(2);
    @(negedge clk);
    chk(adc_conv_en == 1'b1, "R2", "strobe in cycle after arm", adc_conv_en, 1);
    wait_done(cyc);
    chk(mem[2][11:0] == code1(base), "R2", "first stored sample", mem[2][11:0], code1(base));

    // R8: after completion nothing moves
    snap = adc_cnt;
    wsnap = wr_cnt;
    repeat (12) @(negedge clk);
    chk(adc_cnt == snap && wr_cnt == wsnap && host_status[0] == 1'b0, "R8",
        "quiet after completion", adc_cnt - snap + wr_cnt - wsnap, 0);

    // near-exhaustive sweep over rate, decimation code and packing mode
    for (int md = 0; md < 2; md++)
      for (int r = 0; r < 4; r++)
        for (int dc = 0; dc < 10; dc++)
          run_cap(r, (dc == 9) ? 12 : dc, md[0], 3);

    // R3: external start with ignored retriggers
    hw(1'b0, ctrl_word(1, 2, 1'b0, 1'b1, 1'b0));
    hw(1'b1, 5);
    mark_start(5);
    snap = adc_cnt;
    repeat (20) @(negedge clk);
    chk(adc_cnt == snap && wr_cnt == 0 && host_status[0] == 1'b1, "R3",
        "idle while waiting for trigger", adc_cnt - snap + wr_cnt, 0);
    @(negedge clk);
    ext_start = 1'b1;
    @(posedge clk);
    #1;
    mark_start(5);
    repeat (9) @(negedge clk);
    ext_start = 1'b0;
    repeat (3) @(negedge clk);
    ext_start = 1'b1;
    repeat (4) @(negedge clk);
    ext_start = 1'b0;
    wait_done(cyc);
    chk(wr_cnt == 6 && order_err == 0, "R3", "retrigger ignored: order",
        wr_cnt + 1000 * order_err, 6);
    check_buf(5, 1'b0, 2, "R3");
    wsnap = wr_cnt;
    snap = adc_cnt;
    @(negedge clk);
    ext_start = 1'b1;
    repeat (20) @(negedge clk);
    ext_start = 1'b0;
    chk(wr_cnt == wsnap && adc_cnt == snap && host_status[0] == 1'b0, "R3",
        "trigger after completion ignored", wr_cnt - wsnap + adc_cnt - snap, 0);

    // R11: rearm during a capture, with interrupt enabled
    hw(1'b0, ctrl_word(0, 1, 1'b0, 1'b0, 1'b1));
    hw(1'b1, 30);
    mark_start(30);
    repeat (15) @(negedge clk);
    hw(1'b1, 7);
    mark_start(7);
    chk(host_status[0] == 1'b1, "R11", "busy after rearm", host_status[0], 1);
    wait_done(cyc);
    chk(cyc == 1 + LAT + 7, "R11", "cycles after rearm", cyc, 1 + LAT + 7);
    chk(wr_cnt == 8 && order_err == 0, "R11", "rearm order", wr_cnt + 1000 * order_err, 8);
    check_buf(7, 1'b0, 1, "R11");
    chk(irq == 1'b1, "R9", "irq at completion", irq, 1);
    repeat (3) @(negedge clk);
    chk(irq == 1'b1, "R10", "irq held until read", irq, 1);
    host_buf_rd = 1'b1;
    @(posedge clk);
    #1;
    host_buf_rd = 1'b0;
    @(negedge clk);
    chk(irq == 1'b0, "R10", "irq cleared by buffer read", irq, 0);

    // R11: rearm from completed state
    hw(1'b1, 3);
    mark_start(3);
    chk(host_status[0] == 1'b1, "R11", "busy after rearm from done", host_status[0], 1);
    wait_done(cyc);
    check_buf(3, 1'b0, 1, "R11");
    chk(irq == 1'b1, "R9", "irq on second completion", irq, 1);
    hw(1'b1, 3);
    chk(irq == 1'b0, "R10", "irq cleared by arm", irq, 0);
    mark_start(3);
    wait_done(cyc);

    summary();
  end
endmodule